// File: doc/BRIEF.md
# Interrupt-Synchronized Rendezvous Bus Link

This block joins a bus master controller and a bus slave controller that move one fixed-length message at a time over a simple memory-mapped bus. A single interrupt wire provides the synchronization. The slave user asks to take part in a transfer. The slave controller then claims its local I/O port and raises the interrupt. The master side latches the rising interrupt into a slave-ready flag.

Once its own user has asked for a transfer and the flag is set, the master claims its port. It then issues one bus beat per word, either writing to the slave's decoded address window or reading from it. After the last beat it releases the port and clears the flag. The slave waits for its own address to appear on the bus before it takes part. After the final word it drops the interrupt and releases its port.

Both sides block until the other arrives, so nothing is buffered and every message crosses the bus exactly once. The direction is chosen by the master user. A write delivers the master words into the slave's receive register. A read delivers the slave words into the master's receive register.

Top module: `irq_rendezvous_link`

## Requirements
- R1: After reset, irq, m_slv_rdy, bus_valid, bus_we, m_busy, s_busy, m_done and s_done are all 0.
- R2: A slave request raises irq one cycle after the request is sampled, but only while s_port_taken is 0. While s_port_taken is 1 the slave holds irq low and waits. It raises irq in the cycle after the port becomes free.
- R3: A rising edge of irq sets m_slv_rdy one cycle later. The flag stays set after that, including while the master has no request or its port is held, until the master's transfer completes.
- R4: The master issues no bus beat while m_slv_rdy is 0, even when m_req has been given.
- R5: While m_port_taken is 1 the master issues no bus beat. It starts its beats only after the port is free.
- R6: A transfer is exactly WORDS beats on consecutive cycles. Beat k carries address TGT_ADDR+k and word k of the message, where word k sits at bits [k*DW +: DW]. bus_we is 1 on every beat when m_write was 1 at the request (master to slave), and 0 otherwise (slave to master).
- R7: The slave accepts beats only for addresses from SLV_BASE to SLV_BASE+WORDS-1. It stores the word of a write beat in s_rdata, and it answers a read beat with the word of s_wdata at that offset.
- R8: m_done pulses for one cycle, in the cycle after the last beat. In that same cycle m_busy and m_slv_rdy are both 0.
- R9: s_done pulses for one cycle, in the cycle after the last beat. In that same cycle irq and s_busy are 0.
- R10: Each message produces exactly one m_done and one s_done and exactly WORDS beats. This holds whichever side requests first and in back-to-back messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| m_req | input | 1 | Master user request pulse |
| m_write | input | 1 | 1: master sends words, 0: master reads words |
| m_wdata | input | WORDS*DW | Message to send, word k at [k*DW +: DW] |
| m_port_taken | input | 1 | Master-side port held by another task |
| m_rdata | output | WORDS*DW | Message received by the master |
| m_busy | output | 1 | Master holds its port and runs beats |
| m_done | output | 1 | Master completion pulse |
| m_slv_rdy | output | 1 | Latched slave-ready flag |
| s_req | input | 1 | Slave user request pulse |
| s_wdata | input | WORDS*DW | Message the slave returns on a read |
| s_port_taken | input | 1 | Slave-side port held by another task |
| s_rdata | output | WORDS*DW | Message received by the slave |
| s_busy | output | 1 | Slave holds its port and waits for or serves beats |
| s_done | output | 1 | Slave completion pulse |
| irq | output | 1 | Slave-to-master ready interrupt |
| bus_valid | output | 1 | Bus beat strobe |
| bus_we | output | 1 | Beat direction, 1 = write |
| bus_addr | output | AW | Beat address |
| bus_wdata | output | DW | Write data on the bus |
| bus_rdata | output | DW | Read data returned by the slave |

## Verification
The hardest situations to reach are those where the two sides arrive out of order and a local port is held at the same time. Examples are a flag that must survive while the master's port is busy, or a slave that must keep irq low until its own port frees. The stimulus sweeps every combination of:
- transfer direction,
- which side requests first,
- whether the master port is held,
- whether the slave port is held.

Each blocking condition is held for several cycles, and the bench checks that no beat and no interrupt leaks out during that time.

// File: rtl/irq_rendezvous_link.sv
module irq_rendezvous_link #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] SLV_BASE = 16'h0040,
  parameter logic [AW-1:0] TGT_ADDR = 16'h0040
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                m_req,
  input  logic                m_write,
  input  logic [WORDS*DW-1:0] m_wdata,
  input  logic                m_port_taken,
  output logic [WORDS*DW-1:0] m_rdata,
  output logic                m_busy,
  output logic                m_done,
  output logic                m_slv_rdy,
  input  logic                s_req,
  input  logic [WORDS*DW-1:0] s_wdata,
  input  logic                s_port_taken,
  output logic [WORDS*DW-1:0] s_rdata,
  output logic                s_busy,
  output logic                s_done,
  output logic                irq,
  output logic                bus_valid,
  output logic                bus_we,
  output logic [AW-1:0]       bus_addr,
  output logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata
);
  localparam int unsigned CW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CW-1:0] LASTW = CW'(WORDS - 1);

  typedef enum logic [1:0] {M_IDLE, M_WAIT, M_XFER} mst_t;
  typedef enum logic [1:0] {S_IDLE, S_CLAIM, S_WAIT} slv_t;

  mst_t m_st;
  slv_t s_st;
  logic irq_q, m_dir;
  logic [CW-1:0] m_beat, s_cnt, s_off;
  logic [AW-1:0] rel_addr;
  logic hit, m_last, s_last;

  assign irq       = (s_st == S_WAIT);
  assign s_busy    = (s_st == S_WAIT);
  assign bus_valid = (m_st == M_XFER);
  assign m_busy    = (m_st == M_XFER);
  assign bus_we    = bus_valid & m_dir;
  assign bus_addr  = bus_valid ? TGT_ADDR + AW'(m_beat) : '0;
  assign bus_wdata = bus_we ? m_wdata[int'(m_beat)*DW +: DW] : '0;
  assign m_last    = bus_valid && (m_beat == LASTW);

  assign rel_addr  = bus_addr - SLV_BASE;
  assign hit       = (s_st == S_WAIT) && bus_valid && (rel_addr < AW'(WORDS));
  assign s_off     = CW'(rel_addr);
  assign s_last    = hit && (s_cnt == LASTW);
  assign bus_rdata = (hit && !bus_we) ? s_wdata[int'(s_off)*DW +: DW] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= M_IDLE;
      m_dir <= 1'b0;
      m_beat <= '0;
      m_slv_rdy <= 1'b0;
      irq_q <= 1'b0;
      m_done <= 1'b0;
      m_rdata <= '0;
    end else begin
      irq_q <= irq;
      m_done <= m_last;
      if (m_last) m_slv_rdy <= 1'b0;
      else if (irq && !irq_q) m_slv_rdy <= 1'b1;
      if (bus_valid && !m_dir) m_rdata[int'(m_beat)*DW +: DW] <= bus_rdata;
      case (m_st)
        M_IDLE: if (m_req) begin
          m_st <= M_WAIT;
          m_dir <= m_write;
        end
        M_WAIT: if (m_slv_rdy && !m_port_taken) begin
          m_st <= M_XFER;
          m_beat <= '0;
        end
        M_XFER: if (m_last) m_st <= M_IDLE;
                else m_beat <= m_beat + 1'b1;
        default: m_st <= M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_st <= S_IDLE;
      s_cnt <= '0;
      s_done <= 1'b0;
      s_rdata <= '0;
    end else begin
      s_done <= s_last;
      if (hit && bus_we) s_rdata[int'(s_off)*DW +: DW] <= bus_wdata;
      case (s_st)
        S_IDLE: if (s_req) begin
          s_st <= s_port_taken ? S_CLAIM : S_WAIT;
          s_cnt <= '0;
        end
        S_CLAIM: if (!s_port_taken) s_st <= S_WAIT;
        S_WAIT: if (s_last) s_st <= S_IDLE;
                else if (hit) s_cnt <= s_cnt + 1'b1;
        default: s_st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_rendezvous_link_checks.sv
module irq_rendezvous_link_checks (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic m_slv_rdy,
  input logic bus_valid,
  input logic m_busy,
  input logic m_port_taken,
  input logic s_port_taken,
  input logic m_done,
  input logic s_done,
  input logic s_busy
);
  a_r2_irq_port_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !$past(s_port_taken));
  a_r3_flag_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |=> m_slv_rdy);
  a_r4_beat_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> m_slv_rdy);
  a_r5_claim_port_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_busy) |-> !$past(m_port_taken));
  a_r6_beat_while_irq: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> irq);
  a_r8_master_release: assert property (@(posedge clk) disable iff (!rst_n)
    m_done |-> ($past(bus_valid) && !m_slv_rdy && !m_busy));
  a_r9_slave_release: assert property (@(posedge clk) disable iff (!rst_n)
    s_done |-> (!irq && !s_busy));
  a_r10_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    m_done |=> !m_done);
endmodule

bind irq_rendezvous_link irq_rendezvous_link_checks chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .m_slv_rdy(m_slv_rdy),
  .bus_valid(bus_valid), .m_busy(m_busy), .m_port_taken(m_port_taken),
  .s_port_taken(s_port_taken), .m_done(m_done), .s_done(s_done), .s_busy(s_busy));

// File: tb/irq_rendezvous_link_tb.sv
`timescale 1ns/1ps
module irq_rendezvous_link_tb_top;
  localparam int W = 4;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam logic [AW-1:0] BASE = 16'h0040;

  logic clk = 0, rst_n = 0;
  logic m_req = 0, m_write = 0, m_port_taken = 0, s_req = 0, s_port_taken = 0;
  logic [W*DW-1:0] m_wdata = '0, s_wdata = '0;
  logic [W*DW-1:0] m_rdata, s_rdata;
  logic m_busy, m_done, m_slv_rdy, s_busy, s_done, irq, bus_valid, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  irq_rendezvous_link #(.WORDS(W), .DW(DW), .AW(AW), .SLV_BASE(BASE), .TGT_ADDR(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_write(m_write), .m_wdata(m_wdata),
    .m_port_taken(m_port_taken), .m_rdata(m_rdata), .m_busy(m_busy), .m_done(m_done),
    .m_slv_rdy(m_slv_rdy), .s_req(s_req), .s_wdata(s_wdata), .s_port_taken(s_port_taken),
    .s_rdata(s_rdata), .s_busy(s_busy), .s_done(s_done), .irq(irq), .bus_valid(bus_valid),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  int cyc = 0, nb = 0, md_n = 0, sd_n = 0, md_cyc = 0, sd_cyc = 0;
  logic [AW-1:0] a_log [256];
  logic we_log [256];
  int c_log [256];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (bus_valid && nb < 256) begin
      a_log[nb] <= bus_addr; we_log[nb] <= bus_we; c_log[nb] <= cyc; nb <= nb + 1;
    end
    if (m_done) begin md_n <= md_n + 1; md_cyc <= cyc; end
    if (s_done) begin sd_n <= sd_n + 1; sd_cyc <= cyc; end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_m;
    m_req = 1; @(negedge clk); m_req = 0;
  endtask

  task automatic pulse_s;
    s_req = 1; @(negedge clk); s_req = 0;
  endtask

  task automatic run_msg(input int run, input bit dir, input bit s_first, input bit mb, input bit sb);
    int nb0, md0, sd0, t;
    bit ok;
    @(negedge clk);
    for (int k = 0; k < W; k++) begin
      m_wdata[k*DW +: DW] = {8'(run), 8'hA0, 16'(k * 257 + run)};
      s_wdata[k*DW +: DW] = {8'(run), 8'h5B, 16'(k * 771 + run * 3)};
    end
    m_write = dir; m_port_taken = mb; s_port_taken = sb;
    nb0 = nb; md0 = md_n; sd0 = sd_n;
    if (!s_first) begin
      pulse_m; wait_cyc(3);
      chk(nb == nb0, "R4 no beat before slave ready", nb - nb0, 0);
      pulse_s;
    end else begin
      pulse_s; wait_cyc(3);
      if (!sb) begin
        chk(irq == 1, "R2 irq raised", irq, 1);
        chk(m_slv_rdy == 1, "R3 flag set and held", m_slv_rdy, 1);
      end else chk(irq == 0, "R2 irq held low while slave port taken", irq, 0);
      pulse_m;
    end
    if (sb) begin
      wait_cyc(3);
      chk(irq == 0 && nb == nb0, "R2 slave port blocks irq", irq, 0);
      s_port_taken = 0;
    end
    wait_cyc(3);
    if (mb) begin
      chk(nb == nb0, "R5 no beat while master port taken", nb - nb0, 0);
      chk(m_slv_rdy == 1, "R3 flag persists while port held", m_slv_rdy, 1);
      m_port_taken = 0;
    end
    t = 0;
    while ((md_n == md0 || sd_n == sd0) && t < 60) begin @(negedge clk); t++; end
    wait_cyc(2);
    chk(nb - nb0 == W, "R10 beat count", nb - nb0, W);
    chk(md_n - md0 == 1 && sd_n - sd0 == 1, "R10 one done per side", md_n - md0, 1);
    ok = 1;
    for (int k = 0; k < W; k++) begin
      if (a_log[nb0 + k] != BASE + AW'(k)) ok = 0;
      if (we_log[nb0 + k] != dir) ok = 0;
      if (k > 0 && c_log[nb0 + k] != c_log[nb0] + k) ok = 0;
    end
    chk(ok, "R6 addresses, direction, consecutive beats", a_log[nb0], BASE);
    if (dir) chk(s_rdata == m_wdata, "R7 slave receives written words", s_rdata[63:0], m_wdata[63:0]);
    else     chk(m_rdata == s_wdata, "R7 master receives read words", m_rdata[63:0], s_wdata[63:0]);
    chk(md_cyc == c_log[nb0 + W - 1] + 1, "R8 m_done after last beat", md_cyc, c_log[nb0 + W - 1] + 1);
    chk(sd_cyc == c_log[nb0 + W - 1] + 1, "R9 s_done after last beat", sd_cyc, c_log[nb0 + W - 1] + 1);
    chk(!irq && !m_slv_rdy && !m_busy && !s_busy, "R8 R9 released", {irq, m_slv_rdy, m_busy, s_busy}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int run = 1;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(1);
    chk({irq, m_slv_rdy, bus_valid, bus_we, m_busy, s_busy, m_done, s_done} == 0,
        "R1 reset state", {irq, m_slv_rdy, bus_valid, bus_we, m_busy, s_busy, m_done, s_done}, 0);
    for (int d = 0; d < 2; d++)
      for (int o = 0; o < 2; o++)
        for (int mb = 0; mb < 2; mb++)
          for (int sb = 0; sb < 2; sb++) begin
            run_msg(run, d[0], o[0], mb[0], sb[0]);
            run++;
          end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule